// File: doc/BRIEF.md
# Multicore External Interrupt Distributor

This block spreads a set of level-sensitive external interrupt lines across a small cluster of cores. Each line passes through a global enable mask, can be forced active by a software-assert mask, and is then delivered to any subset of cores chosen by a routing word that belongs to that line. For every core the distributor drives a vector of level interrupt outputs: the routed lines sit above the two lowest positions, and a 3-bit inter-processor interrupt value supplied from outside for that core is ORed into the three lowest bits.

Software reaches the block through a simple synchronous read/write port that also reports the index of the core making the access. Besides the masks and routing words, the port exposes a run-stall word that holds cores other than core 0 stopped after reset, an identification word, and a one-bit control flag kept separately for each core. Line 0 is reserved and has no external input. External inputs begin at line 1.

Top module: `irq_distributor`

## Requirements
- R1: The routing word of line k sits at offset k (k below NLINE), reads back as written in its low NCORE bits, and bit c of it delivers line k to core c.
- R2: The enable mask reads at 0x180; writing 1 bits to 0x180 clears those enable bits and writing 1 bits to 0x184 sets them, zero bits leaving the mask unchanged.
- R3: The software-assert mask reads at 0x188, is cleared bitwise by 1 bits written to 0x188 and set bitwise by 1 bits written to 0x184+8 (0x18c); an asserted line is active whatever its enable bit holds.
- R4: Core c's output slice irq_out[c*(NLINE+2) +: NLINE+2] equals (((line_state AND enable) OR assert) AND route column c) shifted left by 2, ORed with the zero-extended ipi_in[3c+2:3c].
- R5: ext_irq[i] drives line i+1; the external state of line 0 is always 0, so line 0 is raised only by software assert.
- R6: After reset the enable mask is all ones over NLINE bits, the assert mask is 0, every routing word is 1 (all lines to core 0), and every irq_out bit is 0 while ipi_in is 0.
- R7: A read at 0x1a0 returns (NCORE-1) shifted left by 18, ORed with req_core.
- R8: The run-stall word at 0x200 is written whole, reads back, drives stall_out bit c for core c, and resets to all ones except bit 0.
- R9: The control word at 0x220 is private to the accessing core (req_core), keeps only bit 0 of a write, reads back in bit 0 with all other bits 0, and resets to 0.
- R10: Reads of any other offset, including 0x184 and 0x18c, return 0; writes to offsets that are not writable change no state.
- R11: rd_data presents a read on the clock edge that accepts it; stall_out changes on the edge that accepts the write; irq_out changes one edge after a register write or on the first edge after an ext_irq or ipi_in change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_irq | input | NLINE-1 | External interrupt levels for lines 1 to NLINE-1 |
| ipi_in | input | 3*NCORE | Inter-processor interrupt bits, three per core |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_core | input | clog2(NCORE) | Index of the core making the access |
| req_addr | input | 10 | Register offset |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| irq_out | output | NCORE*(NLINE+2) | Interrupt vector per core, core 0 in the low slice |
| stall_out | output | NCORE | Run-stall level per core |

## Verification
Each result has a fixed due cycle: read data and stall_out appear at the edge that accepts the access, irq_out follows a register write one edge later and follows an input change at the very next edge. The bench drives on falling edges and compares on falling edges, checking interrupt vectors two edges after any stimulus so both paths have settled. Directed steps also sample the intermediate falling edge after a write to confirm irq_out still shows the old vector, and the edge right after an input change to confirm it already shows the new one.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int IPI_W   = 3;
  localparam int ID_SHIFT = 18;

  localparam logic [ADDR_W-1:0] OFF_EN_CLR = 10'h180;
  localparam logic [ADDR_W-1:0] OFF_EN_SET = 10'h184;
  localparam logic [ADDR_W-1:0] OFF_AS_CLR = 10'h188;
  localparam logic [ADDR_W-1:0] OFF_AS_SET = 10'h18c;
  localparam logic [ADDR_W-1:0] OFF_IDENT  = 10'h1a0;
  localparam logic [ADDR_W-1:0] OFF_STALL  = 10'h200;
  localparam logic [ADDR_W-1:0] OFF_CTL    = 10'h220;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_EN_CLR,
    SEL_EN_SET,
    SEL_AS_CLR,
    SEL_AS_SET,
    SEL_IDENT,
    SEL_STALL_CTL
  } sel_e;
endpackage

// File: rtl/irqd_regfile.sv
module irqd_regfile
  import irqd_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  localparam int CW = $clog2(NCORE),
  localparam int LW = $clog2(NLINE)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [CW-1:0]               req_core,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic [NLINE-1:0][NCORE-1:0] route_q,
  output logic [NLINE-1:0]            en_q,
  output logic [NLINE-1:0]            asg_q,
  output logic [NCORE-1:0]            stall_q,
  output logic [DATA_W-1:0]           rdata_q
);
  localparam logic [NCORE-1:0] ROUTE_RST = NCORE'(1);
  localparam logic [NCORE-1:0] STALL_RST = {{(NCORE-1){1'b1}}, 1'b0};

  sel_e                       sel;
  logic                       is_stall, is_ctl;
  logic                       wr_en, rd_en;
  logic [NLINE-1:0][NCORE-1:0] route_d;
  logic [NLINE-1:0]           en_d, asg_d;
  logic [NCORE-1:0]           stall_d, ctl_q, ctl_d;
  logic [DATA_W-1:0]          rd_val;
  logic [LW-1:0]              line_idx;

  assign wr_en    = req_valid && req_write;
  assign rd_en    = req_valid && !req_write;
  assign line_idx = req_addr[LW-1:0];

  // address decode
  always_comb begin
    sel      = SEL_NONE;
    is_stall = 1'b0;
    is_ctl   = 1'b0;
    if (req_addr < ADDR_W'(NLINE)) begin
      sel = SEL_ROUTE;
    end else begin
      case (req_addr)
        OFF_EN_CLR: sel = SEL_EN_CLR;
        OFF_EN_SET: sel = SEL_EN_SET;
        OFF_AS_CLR: sel = SEL_AS_CLR;
        OFF_AS_SET: sel = SEL_AS_SET;
        OFF_IDENT:  sel = SEL_IDENT;
        OFF_STALL:  begin sel = SEL_STALL_CTL; is_stall = 1'b1; end
        OFF_CTL:    begin sel = SEL_STALL_CTL; is_ctl   = 1'b1; end
        default:    sel = SEL_NONE;
      endcase
    end
  end

  // next state
  always_comb begin
    route_d = route_q;
    en_d    = en_q;
    asg_d   = asg_q;
    stall_d = stall_q;
    ctl_d   = ctl_q;
    if (wr_en) begin
      case (sel)
        SEL_ROUTE:  route_d[line_idx] = req_wdata[NCORE-1:0];
        SEL_EN_CLR: en_d  = en_q  & ~req_wdata[NLINE-1:0];
        SEL_EN_SET: en_d  = en_q  |  req_wdata[NLINE-1:0];
        SEL_AS_CLR: asg_d = asg_q & ~req_wdata[NLINE-1:0];
        SEL_AS_SET: asg_d = asg_q |  req_wdata[NLINE-1:0];
        SEL_STALL_CTL: begin
          if (is_stall) stall_d = req_wdata[NCORE-1:0];
          if (is_ctl)   ctl_d[req_core] = req_wdata[0];
        end
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_ROUTE:  rd_val = DATA_W'(route_q[line_idx]);
      SEL_EN_CLR: rd_val = DATA_W'(en_q);
      SEL_AS_CLR: rd_val = DATA_W'(asg_q);
      SEL_IDENT:  rd_val = (DATA_W'(NCORE - 1) << ID_SHIFT) | DATA_W'(req_core);
      SEL_STALL_CTL: begin
        if (is_stall) rd_val = DATA_W'(stall_q);
        if (is_ctl)   rd_val = DATA_W'(ctl_q[req_core]);
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NLINE{ROUTE_RST}};
      en_q    <= '1;
      asg_q   <= '0;
      stall_q <= STALL_RST;
      ctl_q   <= '0;
    end else if (wr_en) begin
      route_q <= route_d;
      en_q    <= en_d;
      asg_q   <= asg_d;
      stall_q <= stall_d;
      ctl_q   <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assert_en_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == OFF_EN_CLR) |=> ((en_q & $past(req_wdata[NLINE-1:0])) == '0));
  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == OFF_EN_SET) |=> ((en_q & $past(req_wdata[NLINE-1:0])) == $past(req_wdata[NLINE-1:0])));
  assert_as_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_addr == OFF_AS_SET) |=> ((asg_q & $past(req_wdata[NLINE-1:0])) == $past(req_wdata[NLINE-1:0])));
  assert_ident_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr == OFF_IDENT) |=> (rdata_q[DATA_W-1:ID_SHIFT] == (DATA_W-ID_SHIFT)'(NCORE - 1)));
  assert_ctl_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr == OFF_CTL) |=> (rdata_q[DATA_W-1:1] == '0));
  assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && req_addr == OFF_AS_SET) |=> (rdata_q == '0));
  assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(asg_q) && $stable(stall_q)));
endmodule

// File: rtl/irqd_lane.sv
module irqd_lane
  import irqd_pkg::*;
#(
  parameter int NLINE = 8,
  localparam int VW = NLINE + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLINE-1:0] line_act,
  input  logic [NLINE-1:0] col,
  input  logic [IPI_W-1:0] ipi,
  output logic [VW-1:0]    vec_q
);
  logic [VW-1:0] vec_d;
  logic          vec_en;

  always_comb begin
    vec_d  = {line_act & col, 2'b00} | {{(VW-IPI_W){1'b0}}, ipi};
    vec_en = (vec_d != vec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assert_quiet_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (col == '0 && ipi == '0) |=> (vec_q == '0));
  assert_ipi_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (vec_q[1:0] == $past(ipi[1:0])));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int NLINE = 8,
  localparam int CW = $clog2(NCORE),
  localparam int VW = NLINE + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINE-2:0]      ext_irq,
  input  logic [IPI_W*NCORE-1:0] ipi_in,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [CW-1:0]         req_core,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NCORE*VW-1:0]   irq_out,
  output logic [NCORE-1:0]      stall_out
);
  logic [1:0]                  rst_sync;
  logic                        rst_n_i;
  logic [NLINE-1:0][NCORE-1:0] route_q;
  logic [NLINE-1:0]            en_q, asg_q, line_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  irqd_regfile #(.NCORE(NCORE), .NLINE(NLINE)) u_regs (
    .clk(clk), .rst_n(rst_n_i),
    .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .route_q(route_q), .en_q(en_q), .asg_q(asg_q),
    .stall_q(stall_out), .rdata_q(rd_data)
  );

  // line 0 has no external source
  assign line_act = ({ext_irq, 1'b0} & en_q) | asg_q;

  for (genvar c = 0; c < NCORE; c++) begin : g_lane
    logic [NLINE-1:0] col;
    for (genvar k = 0; k < NLINE; k++) begin : g_col
      assign col[k] = route_q[k][c];
    end
    irqd_lane #(.NLINE(NLINE)) u_lane (
      .clk(clk), .rst_n(rst_n_i),
      .line_act(line_act), .col(col),
      .ipi(ipi_in[c*IPI_W +: IPI_W]),
      .vec_q(irq_out[c*VW +: VW])
    );
  end

  assert_line0_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (asg_q[0] == 1'b0 && route_q[0][0] && ipi_in[2] == 1'b0) |=> (irq_out[2] == 1'b0));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (asg_q[1] && route_q[1][0]) |=> irq_out[3]);
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int NCORE = 4;
  localparam int NLINE = 8;
  localparam int CW = $clog2(NCORE);
  localparam int VW = NLINE + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NLINE-2:0]   ext_irq = '0;
  logic [3*NCORE-1:0] ipi_in = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [CW-1:0] req_core = '0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic [NCORE*VW-1:0] irq_out;
  logic [NCORE-1:0] stall_out;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [NCORE-1:0] route_m [NLINE];
  logic [NLINE-1:0] en_m, asg_m;
  logic [NCORE-1:0] stall_m, ctl_m;

  always #10 clk = ~clk;

  irq_distributor #(.NCORE(NCORE), .NLINE(NLINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .ipi_in(ipi_in),
    .req_valid(req_valid), .req_write(req_write), .req_core(req_core),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .irq_out(irq_out), .stall_out(stall_out));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] exp_vec(input int c);
    logic [NLINE-1:0] lines, col;
    lines = ({ext_irq, 1'b0} & en_m) | asg_m;
    for (int k = 0; k < NLINE; k++) col[k] = route_m[k][c];
    return {lines & col, 2'b00} | {{(VW-3){1'b0}}, ipi_in[c*3 +: 3]};
  endfunction

  function automatic logic [NCORE*VW-1:0] exp_all();
    logic [NCORE*VW-1:0] r;
    for (int c = 0; c < NCORE; c++) r[c*VW +: VW] = exp_vec(c);
    return r;
  endfunction

  task automatic model_wr(input int core, input logic [9:0] a, input logic [31:0] d);
    if (a < NLINE) route_m[a] = d[NCORE-1:0];
    else case (a)
      10'h180: en_m  = en_m  & ~d[NLINE-1:0];
      10'h184: en_m  = en_m  |  d[NLINE-1:0];
      10'h188: asg_m = asg_m & ~d[NLINE-1:0];
      10'h18c: asg_m = asg_m |  d[NLINE-1:0];
      10'h200: stall_m = d[NCORE-1:0];
      10'h220: ctl_m[core] = d[0];
      default: ;
    endcase
  endtask

  // returns at the falling edge after the accepting edge
  task automatic do_wr(input int core, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_core = CW'(core); req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    model_wr(core, a, d);
  endtask

  task automatic do_rd(input string req, input int core, input logic [9:0] a, input logic [31:0] exp);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_core = CW'(core); req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req, rd_data, exp);
  endtask

  task automatic check_all(input string req);
    @(negedge clk); @(negedge clk);
    chk(req, irq_out, exp_all());
    chk({req, " R8 stall"}, stall_out, stall_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NCORE*VW-1:0] old_v;
    for (int k = 0; k < NLINE; k++) route_m[k] = NCORE'(1);
    en_m = '1; asg_m = '0; stall_m = 4'b1110; ctl_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 / R8 reset state
    chk("R6 irq reset", irq_out, '0);
    chk("R8 stall reset", stall_out, 4'b1110);
    do_rd("R6 enable reset", 0, 10'h180, 32'h0000_00ff);
    do_rd("R6 assert reset", 0, 10'h188, 32'h0);
    do_rd("R6 route reset", 0, 10'h003, 32'h1);
    do_rd("R9 ctl reset", 1, 10'h220, 32'h0);
    do_rd("R8 stall read", 0, 10'h200, 32'h0000_000e);
    do_rd("R7 ident", 2, 10'h1a0, (32'd3 << 18) | 32'd2);
    do_rd("R7 ident core3", 3, 10'h1a0, (32'd3 << 18) | 32'd3);

    // R11 input path: one edge after ext change; R5 ext_irq[0] is line 1 (bit 3)
    @(negedge clk);
    ext_irq[0] = 1'b1;
    @(negedge clk);
    chk("R11 R5 ext to core0 bit3", irq_out[VW-1:0], 10'b00_0000_1000);

    // R11 write path: old value after accepting edge, new one edge later
    old_v = exp_all();
    do_wr(0, 10'h180, 32'h2);
    chk("R11 write lag", irq_out, old_v);
    @(negedge clk);
    chk("R2 enable clear drops line1", irq_out, exp_all());
    do_rd("R2 enable readback", 0, 10'h180, 32'h0000_00fd);

    do_wr(0, 10'h18c, 32'h2);
    check_all("R3 assert bypasses enable");
    do_rd("R3 assert readback", 0, 10'h188, 32'h2);
    do_wr(0, 10'h188, 32'h2);
    check_all("R3 assert clear");
    do_wr(0, 10'h184, 32'h2);
    check_all("R2 enable set");

    do_wr(0, 10'h001, 32'hffff_fff0 | 32'ha);
    check_all("R1 route line1 to cores 1 and 3");
    do_rd("R1 route readback", 0, 10'h001, 32'ha);

    // R5 line 0: only software assert raises bit 2
    do_wr(0, 10'h000, 32'hf);
    check_all("R5 line0 no external source");
    do_wr(0, 10'h18c, 32'h1);
    check_all("R5 line0 via assert");
    chk("R5 core2 bit2", irq_out[2*VW + 2], 1'b1);

    // R4 ipi bits
    @(negedge clk);
    ipi_in = 12'b101_010_111_001;
    check_all("R4 ipi merge");

    // R9 control per core
    do_wr(1, 10'h220, 32'hffff_ffff);
    do_rd("R9 ctl own core", 1, 10'h220, 32'h1);
    do_rd("R9 ctl other core", 0, 10'h220, 32'h0);

    // R8 stall
    do_wr(2, 10'h200, 32'hffff_fff5);
    chk("R8 stall on accept edge", stall_out, 4'h5);

    // R10 unmapped
    do_rd("R10 read 0x100", 0, 10'h100, 32'h0);
    do_rd("R10 read en set", 0, 10'h184, 32'h0);
    do_rd("R10 read as set", 0, 10'h18c, 32'h0);
    do_wr(0, 10'h300, 32'hffff_ffff);
    do_wr(0, 10'h008, 32'h0);
    do_wr(0, 10'h1a0, 32'hffff_ffff);
    check_all("R10 ignored writes");
    do_rd("R10 enable intact", 0, 10'h180, 32'h0000_00ff);
    do_rd("R10 stall intact", 0, 10'h200, 32'h5);

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int it = 0; it < 200; it++) begin
      int op;
      logic [31:0] d;
      op = $urandom_range(0, 7);
      d = $urandom();
      case (op)
        0: do_wr($urandom_range(0, NCORE-1), 10'($urandom_range(0, NLINE-1)), d);
        1: do_wr(0, 10'h180, d & 32'h3);
        2: do_wr(0, 10'h184, d);
        3: do_wr(1, 10'h188, d);
        4: do_wr(2, 10'h18c, d & 32'h11);
        5: do_wr(3, 10'h200, d);
        6: begin @(negedge clk); ext_irq = d[NLINE-2:0]; end
        default: begin @(negedge clk); ipi_in = d[3*NCORE-1:0]; end
      endcase
      check_all("R4 R1 random");
    end
    do_rd("R2 final enable", 0, 10'h180, 32'(en_m));
    do_rd("R3 final assert", 0, 10'h188, 32'(asg_m));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule